// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two IEEE 754 binary32 operands under one of four rounding modes. The result comes out of a single register stage. Each operand is first sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. A resolver then settles every pair that involves a NaN, an infinity or a zero, without arithmetic.

All other pairs are finite and nonzero. For these, the block aligns the extended mantissas and adds or subtracts them by magnitude. It then normalizes, rounds and packs the result. Four exception flags travel with the result: invalid operation, overflow, underflow and inexact.

A new operation may be presented on every clock with `in_valid` high. Its result and flags appear on the next clock with `out_valid` high.

Top module: `fpadd_sp`

## Requirements
- R1: Reset is synchronous and active high. It clears `out_valid`, `result` and all four flags. Outputs update one clock after an operation is accepted on `in_valid`, and `out_valid` is `in_valid` delayed by one clock.
- R2: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. It is a signalling NaN when fraction bit 22 is 0. If either operand is a signalling NaN, the result is the default quiet NaN 0x7FC00000 and `flag_invalid` is set.
- R3: With no signalling NaN present, a quiet NaN in `op_a` is returned unchanged. Otherwise a quiet NaN in `op_b` is returned unchanged. No flag is raised.
- R4: Two infinities of equal sign return that infinity. Two infinities of opposite sign return 0x7FC00000 and set `flag_invalid`, with no other flag.
- R5: An infinity plus a zero or a finite operand returns the infinity. A zero plus a finite nonzero operand returns the nonzero operand bit for bit, with no flags.
- R6: Two zeros of equal sign return that zero. Two zeros of opposite sign, or an exact cancellation of finite operands, return +0, except under mode 11, which returns −0.
- R7: Finite operands are aligned to the larger exponent. Bits shifted out are kept as a sticky bit, and a carry out of the sum renormalizes right. A difference takes the sign of the larger magnitude and is normalized left.
- R8: `rmode` encodes 00 as nearest-even, 01 as toward zero, 10 as toward +∞ and 11 as toward −∞. `flag_inexact` is set whenever discarded bits are nonzero.
- R9: When the rounded exponent reaches 255, the result is set by mode and sign. It is infinity under nearest-even, and under the directed mode that points away from zero. It is the largest finite magnitude under the other modes. `flag_overflow` and `flag_inexact` are both set.
- R10: Denormal operands take part in arithmetic at their true value. A nonzero result below the normal range is packed with exponent field 0 and sets `flag_underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Rounded binary32 sum |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Result overflowed |
| flag_underflow | output | 1 | Nonzero result is below the normal range |
| flag_inexact | output | 1 | Result was rounded |

## Verification
The properties assume that `in_valid` is a known level on every clock after reset. They also assume that operands offered with `in_valid` high belong to that cycle only. The NaN properties decode the operand classes straight from `op_a` and `op_b`, so they take any bit pattern as legal input. The stimulus changes the operands, mode and `in_valid` only on falling edges, and holds `in_valid` low throughout reset. The sequence also includes an idle gap, so that the valid pipeline is seen dropping as well as rising.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } fp_class_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;

endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output fp_class_e             cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    if (&exp_f) begin
      if (frac_f == '0)            cls = CLS_INF;
      else if (frac_f[FRAC_W-1])   cls = CLS_QNAN;
      else                         cls = CLS_SNAN;
    end else if (exp_f == '0) begin
      cls = (frac_f == '0) ? CLS_ZERO : CLS_DENORM;
    end else begin
      cls = CLS_NORMAL;
    end
  end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  fp_class_e             cls_a,
  input  fp_class_e             cls_b,
  input  rmode_e                rmode,
  output logic                  hit,
  output logic [EXP_W+FRAC_W:0] res,
  output fp_flags_t             flags
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QNAN_DEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic sign_a, sign_b;
  assign sign_a = a[W-1];
  assign sign_b = b[W-1];

  always_comb begin
    hit   = 1'b1;
    res   = a;
    flags = '0;
    if (cls_a == CLS_SNAN || cls_b == CLS_SNAN) begin
      res           = QNAN_DEF;
      flags.invalid = 1'b1;
    end else if (cls_a == CLS_QNAN) begin
      res = a;
    end else if (cls_b == CLS_QNAN) begin
      res = b;
    end else if (cls_a == CLS_INF && cls_b == CLS_INF) begin
      if (sign_a == sign_b) begin
        res = a;
      end else begin
        res           = QNAN_DEF;
        flags.invalid = 1'b1;
      end
    end else if (cls_a == CLS_INF) begin
      res = a;
    end else if (cls_b == CLS_INF) begin
      res = b;
    end else if (cls_a == CLS_ZERO && cls_b == CLS_ZERO) begin
      if (sign_a == sign_b) res = a;
      else                  res = {rmode == RM_DOWN, {(W-1){1'b0}}};
    end else if (cls_a == CLS_ZERO) begin
      res = b;
    end else if (cls_b == CLS_ZERO) begin
      res = a;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  rmode_e                rmode,
  output logic [EXP_W+FRAC_W:0] res,
  output fp_flags_t             flags
);
  localparam int W        = 1 + EXP_W + FRAC_W;
  localparam int MW       = FRAC_W + 1;     // mantissa with hidden bit
  localparam int XW       = MW + 3;         // plus guard, round, sticky
  localparam int SW       = XW + 1;         // plus carry
  localparam int EIW      = EXP_W + 2;      // internal exponent width
  localparam int EXP_ONES = (1 << EXP_W) - 1;

  function automatic logic [EIW-1:0] lead_zeros(input logic [XW-1:0] v);
    logic [EIW-1:0] cnt;
    cnt = EIW'(XW);
    for (int i = 0; i < XW; i++) begin
      if (v[i]) cnt = EIW'(XW - 1 - i);
    end
    return cnt;
  endfunction

  // operand ordering by magnitude
  logic             swap;
  logic [W-1:0]     big, sml;
  logic [EXP_W-1:0] eb, es, ediff;
  logic [MW-1:0]    mb, ms;
  logic             sgn, eff_sub;

  always_comb begin
    swap    = b[W-2:0] > a[W-2:0];
    big     = swap ? b : a;
    sml     = swap ? a : b;
    eb      = (big[W-2:FRAC_W] == '0) ? EXP_W'(1) : big[W-2:FRAC_W];
    es      = (sml[W-2:FRAC_W] == '0) ? EXP_W'(1) : sml[W-2:FRAC_W];
    mb      = {big[W-2:FRAC_W] != '0, big[FRAC_W-1:0]};
    ms      = {sml[W-2:FRAC_W] != '0, sml[FRAC_W-1:0]};
    ediff   = eb - es;
    sgn     = big[W-1];
    eff_sub = a[W-1] ^ b[W-1];
  end

  // alignment with sticky collection
  logic [XW-1:0] mx, my, my_sh, my_back, my_al;
  always_comb begin
    mx      = {mb, 3'b000};
    my      = {ms, 3'b000};
    my_sh   = my >> ediff;
    my_back = my_sh << ediff;
    my_al   = my_sh | {{(XW-1){1'b0}}, my_back != my};
  end

  // add or subtract magnitudes
  logic [SW-1:0] s;
  logic          cancel;
  always_comb begin
    if (eff_sub) s = {1'b0, mx} - {1'b0, my_al};
    else         s = {1'b0, mx} + {1'b0, my_al};
    cancel = (s == '0);
  end

  // normalization, bounded below by the smallest normal exponent
  logic [XW-1:0]  n;
  logic [EIW-1:0] en, lz, lim, sh;
  always_comb begin
    lz  = lead_zeros(s[XW-1:0]);
    lim = EIW'(eb) - EIW'(1);
    sh  = (lz < lim) ? lz : lim;
    if (s[SW-1]) begin
      n  = s[SW-1:1] | {{(XW-1){1'b0}}, s[0]};
      en = EIW'(eb) + EIW'(1);
    end else begin
      n  = s[XW-1:0] << sh;
      en = EIW'(eb) - sh;
    end
  end

  // rounding
  logic [MW-1:0]  kept, mfin;
  logic [MW:0]    rsum;
  logic           g_bit, r_bit, s_bit, inexact, inc;
  logic [EIW-1:0] efin;
  always_comb begin
    kept    = n[XW-1:3];
    g_bit   = n[2];
    r_bit   = n[1];
    s_bit   = n[0];
    inexact = g_bit | r_bit | s_bit;
    unique case (rmode)
      RM_NEAREST: inc = g_bit & (r_bit | s_bit | kept[0]);
      RM_ZERO:    inc = 1'b0;
      RM_UP:      inc = inexact & ~sgn;
      RM_DOWN:    inc = inexact & sgn;
      default:    inc = 1'b0;
    endcase
    rsum = {1'b0, kept} + {{MW{1'b0}}, inc};
    if (rsum[MW]) begin
      mfin = rsum[MW:1];
      efin = en + EIW'(1);
    end else begin
      mfin = rsum[MW-1:0];
      efin = en;
    end
  end

  // packing
  logic ovf, to_inf;
  always_comb begin
    ovf    = efin >= EIW'(EXP_ONES);
    to_inf = (rmode == RM_NEAREST) || (rmode == RM_UP && !sgn) || (rmode == RM_DOWN && sgn);
    flags  = '0;
    if (cancel) begin
      res = {rmode == RM_DOWN, {(W-1){1'b0}}};
    end else if (ovf) begin
      res            = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                              : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      flags.overflow = 1'b1;
      flags.inexact  = 1'b1;
    end else begin
      res             = {sgn, mfin[MW-1] ? efin[EXP_W-1:0] : {EXP_W{1'b0}}, mfin[FRAC_W-1:0]};
      flags.inexact   = inexact;
      flags.underflow = ~mfin[MW-1];
    end
  end
endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic [1:0]            rmode,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flag_invalid,
  output logic                  flag_overflow,
  output logic                  flag_underflow,
  output logic                  flag_inexact
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int N_OPS = 2;

  logic [W-1:0] ops [N_OPS];
  fp_class_e    cls [N_OPS];
  rmode_e       rm;

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign rm     = rmode_e'(rmode);

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[i]),
      .cls (cls[i])
    );
  end

  logic         sp_hit;
  logic [W-1:0] sp_res, ar_res;
  fp_flags_t    sp_flags, ar_flags;

  fpadd_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
    .a     (op_a),
    .b     (op_b),
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .rmode (rm),
    .hit   (sp_hit),
    .res   (sp_res),
    .flags (sp_flags)
  );

  fpadd_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
    .a     (op_a),
    .b     (op_b),
    .rmode (rm),
    .res   (ar_res),
    .flags (ar_flags)
  );

  logic [W-1:0] nxt_res;
  fp_flags_t    nxt_flags;
  assign nxt_res   = sp_hit ? sp_res : ar_res;
  assign nxt_flags = sp_hit ? sp_flags : ar_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      result         <= '0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result         <= nxt_res;
        flag_invalid   <= nxt_flags.invalid;
        flag_overflow  <= nxt_flags.overflow;
        flag_underflow <= nxt_flags.underflow;
        flag_inexact   <= nxt_flags.inexact;
      end
    end
  end
endmodule

// File: rtl/fpadd_sp_chk.sv
module fpadd_sp_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  flag_invalid,
  input logic                  flag_overflow,
  input logic                  flag_underflow,
  input logic                  flag_inexact
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QNAN_DEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_nan, b_nan, a_snan, b_snan, a_qnan;
  assign a_nan  = (&op_a[W-2:FRAC_W]) && (op_a[FRAC_W-1:0] != '0);
  assign b_nan  = (&op_b[W-2:FRAC_W]) && (op_b[FRAC_W-1:0] != '0);
  assign a_snan = a_nan && !op_a[FRAC_W-1];
  assign b_snan = b_nan && !op_b[FRAC_W-1];
  assign a_qnan = a_nan && op_a[FRAC_W-1];

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_snan_default_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && (a_snan || b_snan) |=> flag_invalid && result == QNAN_DEF);

  assert_qnan_first_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && a_qnan && !b_snan |=> result == $past(op_a) && !flag_invalid);

  assert_invalid_alone_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_invalid |-> result == QNAN_DEF && !flag_overflow && !flag_underflow && !flag_inexact);

  assert_no_overflow_exact_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_overflow |-> flag_inexact && !flag_underflow);

  assert_underflow_packed_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_underflow |-> result[W-2:FRAC_W] == '0 && result[FRAC_W-1:0] != '0);
endmodule

bind fpadd_sp fpadd_sp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .op_a           (op_a),
  .op_b           (op_b),
  .out_valid      (out_valid),
  .result         (result),
  .flag_invalid   (flag_invalid),
  .flag_overflow  (flag_overflow),
  .flag_underflow (flag_underflow),
  .flag_inexact   (flag_inexact)
);

// File: tb/tb_fpadd_sp.sv
`timescale 1ns/1ps
module tb_fpadd_sp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  rmode = 2'b00;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

  always #2 clk = ~clk;   // 250 MHz

  fpadd_sp dut (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .op_a           (op_a),
    .op_b           (op_b),
    .rmode          (rmode),
    .out_valid      (out_valid),
    .result         (result),
    .flag_invalid   (flag_invalid),
    .flag_overflow  (flag_overflow),
    .flag_underflow (flag_underflow),
    .flag_inexact   (flag_inexact)
  );

  typedef struct {
    logic [31:0] res;
    logic [3:0]  fl;     // {invalid, overflow, underflow, inexact}
    int          req;
  } exp_t;

  exp_t sb_q[$];
  exp_t item;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  localparam logic [3:0] F_NONE = 4'b0000;
  localparam logic [3:0] F_INV  = 4'b1000;
  localparam logic [3:0] F_OVX  = 4'b0101;
  localparam logic [3:0] F_UN   = 4'b0010;
  localparam logic [3:0] F_INX  = 4'b0001;

  task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic [1:0] m,
                       input logic [31:0] er, input logic [3:0] ef, input int req);
    exp_t e;
    @(negedge clk);
    op_a = x; op_b = y; rmode = m; in_valid = 1'b1;
    e.res = er; e.fl = ef; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected out_valid, actual result %h, expected no output", result);
      end else begin
        item = sb_q.pop_front();
        if (result !== item.res ||
            {flag_invalid, flag_overflow, flag_underflow, flag_inexact} !== item.fl) begin
          fails++;
          $display("FAIL R%0d: actual %h flags %b, expected %h flags %b", item.req, result,
                   {flag_invalid, flag_overflow, flag_underflow, flag_inexact}, item.res, item.fl);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 ||
        {flag_invalid, flag_overflow, flag_underflow, flag_inexact} !== 4'b0) begin
      fails++;
      $display("FAIL R1: reset state actual v=%b %h, expected v=0 00000000", out_valid, result);
    end

    // R2 signalling NaN
    drive(32'h7F800001, 32'h3F800000, 2'b00, 32'h7FC00000, F_INV, 2);
    drive(32'h7FC00001, 32'hFF800001, 2'b00, 32'h7FC00000, F_INV, 2);
    // R3 quiet NaN priority
    drive(32'h3F800000, 32'h7FC12345, 2'b00, 32'h7FC12345, F_NONE, 3);
    drive(32'hFFC00010, 32'h7FC00020, 2'b00, 32'hFFC00010, F_NONE, 3);
    // R4 infinities
    drive(32'h7F800000, 32'h7F800000, 2'b00, 32'h7F800000, F_NONE, 4);
    drive(32'h7F800000, 32'hFF800000, 2'b00, 32'h7FC00000, F_INV, 4);
    // R5 infinity and zero with finite
    drive(32'hFF800000, 32'h3F800000, 2'b00, 32'hFF800000, F_NONE, 5);
    drive(32'h3F800000, 32'hFF800000, 2'b00, 32'hFF800000, F_NONE, 5);
    drive(32'h00000000, 32'h00000001, 2'b00, 32'h00000001, F_NONE, 5);
    drive(32'h80000000, 32'h40490FDB, 2'b11, 32'h40490FDB, F_NONE, 5);

    // idle gap: R1 no output while in_valid is low
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R6 zero sums
    drive(32'h80000000, 32'h80000000, 2'b00, 32'h80000000, F_NONE, 6);
    drive(32'h00000000, 32'h80000000, 2'b00, 32'h00000000, F_NONE, 6);
    drive(32'h00000000, 32'h80000000, 2'b11, 32'h80000000, F_NONE, 6);
    drive(32'h3F800000, 32'hBF800000, 2'b00, 32'h00000000, F_NONE, 6);
    drive(32'h3F800000, 32'hBF800000, 2'b11, 32'h80000000, F_NONE, 6);
    // R7 arithmetic paths
    drive(32'h3F800000, 32'h3F800000, 2'b00, 32'h40000000, F_NONE, 7);
    drive(32'h3F800000, 32'h40000000, 2'b00, 32'h40400000, F_NONE, 7);
    drive(32'h40000000, 32'hBF800000, 2'b00, 32'h3F800000, F_NONE, 7);
    drive(32'h3F800001, 32'hBF800000, 2'b00, 32'h34000000, F_NONE, 7);
    drive(32'h3F800000, 32'hC0000000, 2'b00, 32'hBF800000, F_NONE, 7);
    // R8 rounding
    drive(32'h3F800000, 32'h33800000, 2'b00, 32'h3F800000, F_INX, 8);
    drive(32'h3F800000, 32'h33800000, 2'b10, 32'h3F800001, F_INX, 8);
    drive(32'h3F800000, 32'h33800000, 2'b01, 32'h3F800000, F_INX, 8);
    drive(32'h3F800001, 32'h33800000, 2'b00, 32'h3F800002, F_INX, 8);
    drive(32'hBF800000, 32'hB3800000, 2'b11, 32'hBF800001, F_INX, 8);
    drive(32'hBF800000, 32'hB3800000, 2'b10, 32'hBF800000, F_INX, 8);
    drive(32'h3F800000, 32'hB2800000, 2'b00, 32'h3F800000, F_INX, 8);
    drive(32'h3F800000, 32'hB2800000, 2'b01, 32'h3F7FFFFF, F_INX, 8);
    // R9 overflow
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b00, 32'h7F800000, F_OVX, 9);
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b01, 32'h7F7FFFFF, F_OVX, 9);
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b11, 32'h7F7FFFFF, F_OVX, 9);
    drive(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b11, 32'hFF800000, F_OVX, 9);
    drive(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b10, 32'hFF7FFFFF, F_OVX, 9);
    // R10 denormals
    drive(32'h00000001, 32'h00000001, 2'b00, 32'h00000002, F_UN, 10);
    drive(32'h00800000, 32'h80000001, 2'b00, 32'h007FFFFF, F_UN, 10);
    drive(32'h00400000, 32'h00400000, 2'b00, 32'h00800000, F_NONE, 10);

    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R1: every accepted operation produced exactly one result
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R1: pending results actual %0d, expected 0", sb_q.size());
    end
    done = 1;
    summary();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1: watchdog expired, actual pending %0d, expected 0", sb_q.size());
      summary();
    end
  end
endmodule